// File: doc/BRIEF.md
# Prioritized Interrupt and Exception Entry Controller

This block sits next to a small processor core and decides, cycle by cycle, whether the core must enter a handler. Three kinds of event compete. The first is an undefined-opcode exception from the decoder. The second is a non-maskable interrupt line. The third is a set of peripheral request lines, each with its own enable bit. The block holds the shared priority-level registers for the peripherals, the current interrupt level mask, the global enable flag and the stack-select flag. When an event is taken, it emits a one-cycle accept strobe together with a vector number.

On every entry the block saves the mask, both flags and its own "inside undefined-opcode handler" state on a small internal stack. It then applies the entry rules for that kind of event. When the core signals a return from a handler, the block pops the stack and restores the saved state. Pushing the program counter and fetching the vector stay with the core.

Software programs the block through a simple write port with three kinds of address. Addresses `0 .. NUM_SRC/2-1` select a shared level register. Address `NUM_SRC/2` selects the level mask. Address `NUM_SRC/2+1` selects the flags, with bit 0 as the global enable and bit 1 as the stack select.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the block is idle with these values: no accept strobe, mask 31, global enable 0, stack select 1, error 0, every level register 31. With level 31 everywhere, no peripheral request is ever taken.
- R2: Level register k sets the level of sources 2k and 2k+1. A written value below 16 is stored as 16.
- R3: A peripheral source qualifies only when all of these hold: its request is high, its enable is high, the global enable is 1, its level is not 31, and its level is at or below the mask.
- R4: Among qualifying sources the lowest level wins, and a tie goes to the lower source index. The vector is `PERIPH_VEC_BASE` + index (16 + index by default).
- R5: When a peripheral is taken, the mask becomes that source's level and the global enable keeps its value.
- R6: A mask write below 16 stores 16. Any other value is stored unchanged.
- R7: A rising edge on the NMI line is taken with vector 15, whatever the global enable and the mask are. On entry the mask becomes 15, so peripherals at level 16 or above are held off.
- R8: An undefined-opcode strobe always wins and is taken with vector 14. On entry it clears the global enable. NMI stays pending, and is not taken, until that handler returns.
- R9: Every entry clears the stack-select flag.
- R10: A return strobe restores the mask, the global enable, the stack select and the undefined-handler state that the matching entry saved. A return with an empty stack changes nothing.
- R11: The save stack holds 4 entries. A fifth nested entry sets a sticky error flag and is not stored, so the first four entries still come back in order.
- R12: The accept strobe lasts exactly one cycle per acceptance. No event is accepted in a cycle that carries a return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | NUM_SRC | Peripheral cause pending, one bit per source |
| src_en | input | NUM_SRC | Peripheral local enable, one bit per source |
| nmi_in | input | 1 | Non-maskable interrupt line, taken on its rising edge |
| undef_stb | input | 1 | One-cycle strobe from the decoder for an undefined opcode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: level register, mask, or flags |
| wr_data | input | 5 | Write data |
| reti_stb | input | 1 | Return-from-handler strobe |
| take_stb | output | 1 | One-cycle accept strobe |
| take_vec | output | VEC_W | Vector number of the accepted event, valid with take_stb |
| ilm_o | output | 5 | Current interrupt level mask |
| ien_o | output | 1 | Current global enable flag |
| ssel_o | output | 1 | Current stack-select flag |
| stk_err | output | 1 | Sticky save-stack overflow flag |

## Verification
The block makes each decision from the inputs seen at one rising edge. The accept strobe, the vector, the mask and both flags all change at that same edge, so every result is due one cycle after its stimulus. A pending NMI that waited for an undefined-opcode handler to finish is accepted one cycle after the return cycle. Reset adds two cycles of synchronizer latency. The bench changes inputs just after a falling edge and reads the outputs at the next falling edge, half a cycle after the edge that produced them. For the held-off cases it also reads the strobe on each of the following cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W     = 5;
  localparam int LVL_OFF   = 31;
  localparam int LVL_FLOOR = 16;
  localparam int LVL_NMI   = 15;

  typedef struct packed {
    logic [LVL_W-1:0] ilm;
    logic             ien;
    logic             ssel;
    logic             in_undef;
  } save_t;
endpackage

// File: rtl/irq_level_bank.sv
module irq_level_bank
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [LVL_W-1:0]                wr_data,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   src_lvl
);
  localparam int NUM_PAIR = NUM_SRC / 2;

  logic [LVL_W-1:0] wr_clamped;
  assign wr_clamped = (wr_data < LVL_W'(LVL_FLOOR)) ? LVL_W'(LVL_FLOOR) : wr_data;

  for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             lvl_we;

    assign lvl_we = wr_en && (wr_addr == ADDR_W'(k));

    always_comb begin
      lvl_d = lvl_q;
      if (lvl_we) lvl_d = wr_clamped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= LVL_W'(LVL_OFF);
      else        lvl_q <= lvl_d;
    end

    assign src_lvl[2*k]   = lvl_q;
    assign src_lvl[2*k+1] = lvl_q;

    // R2: a stored level never drops below the software floor
    assert_lvl_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q >= LVL_W'(LVL_FLOOR));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]              req,
  input  logic [NUM_SRC-1:0]              en,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]   src_lvl,
  input  logic [LVL_W-1:0]                ilm,
  input  logic                            ien,
  output logic                            found,
  output logic [IDX_W-1:0]                win_idx,
  output logic [LVL_W-1:0]                win_lvl
);
  logic [NUM_SRC-1:0] qual;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_qual
    assign qual[i] = req[i] && en[i] && ien &&
                     (src_lvl[i] != LVL_W'(LVL_OFF)) && (src_lvl[i] <= ilm);
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = LVL_W'(LVL_OFF);
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!found || (src_lvl[i] < win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_save_stack.sv
module irq_save_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  logic  pop,
  input  save_t push_ent,
  output save_t top_ent,
  output logic  full,
  output logic  empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  save_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] top_pos;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign top_pos = cnt_q - 1'b1;
  assign top_ent = mem[top_pos[IDX_W-1:0]];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[cnt_q[IDX_W-1:0]] <= push_ent;
  end

  // R11: occupancy never exceeds the depth
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R10: entry and return are never requested together
  assert_push_pop_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC         = 8,
  parameter int STACK_DEPTH     = 4,
  parameter int VEC_W           = 8,
  parameter int PERIPH_VEC_BASE = 16,
  parameter int UNDEF_VEC       = 14,
  parameter int NMI_VEC         = 15,
  parameter int ADDR_W          = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               nmi_in,
  input  logic               undef_stb,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LVL_W-1:0]   wr_data,
  input  logic               reti_stb,
  output logic               take_stb,
  output logic [VEC_W-1:0]   take_vec,
  output logic [LVL_W-1:0]   ilm_o,
  output logic               ien_o,
  output logic               ssel_o,
  output logic               stk_err
);
  localparam int NUM_PAIR   = NUM_SRC / 2;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int ADDR_ILM   = NUM_PAIR;
  localparam int ADDR_FLAGS = NUM_PAIR + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic                          win_found;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;
  save_t                         push_ent, top_ent;
  logic                          push, pop, stk_full, stk_empty;

  logic [LVL_W-1:0] ilm_q, ilm_d;
  logic             ien_q, ien_d, ssel_q, ssel_d, undef_q, undef_d;
  logic             nmi_prev_q, nmi_pend_q, nmi_pend_d;
  logic             take_q, take_d, err_q, err_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  irq_level_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_lvl(src_lvl)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req(src_req), .en(src_en), .src_lvl(src_lvl), .ilm(ilm_q), .ien(ien_q),
    .found(win_found), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  irq_save_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n_s), .push(push), .pop(pop), .push_ent(push_ent),
    .top_ent(top_ent), .full(stk_full), .empty(stk_empty)
  );

  assign push_ent = '{ilm: ilm_q, ien: ien_q, ssel: ssel_q, in_undef: undef_q};

  always_comb begin
    ilm_d      = ilm_q;
    ien_d      = ien_q;
    ssel_d     = ssel_q;
    undef_d    = undef_q;
    err_d      = err_q;
    nmi_pend_d = nmi_pend_q | (nmi_in & ~nmi_prev_q);
    take_d     = 1'b0;
    vec_d      = '0;
    push       = 1'b0;
    pop        = 1'b0;
    if (reti_stb) begin
      pop = 1'b1;
      if (!stk_empty) begin
        ilm_d   = top_ent.ilm;
        ien_d   = top_ent.ien;
        ssel_d  = top_ent.ssel;
        undef_d = top_ent.in_undef;
      end
    end else if (undef_stb) begin
      take_d  = 1'b1;
      vec_d   = VEC_W'(UNDEF_VEC);
      push    = 1'b1;
      ien_d   = 1'b0;
      ssel_d  = 1'b0;
      undef_d = 1'b1;
    end else if (nmi_pend_d && !undef_q) begin
      take_d     = 1'b1;
      vec_d      = VEC_W'(NMI_VEC);
      push       = 1'b1;
      ilm_d      = LVL_W'(LVL_NMI);
      ssel_d     = 1'b0;
      nmi_pend_d = 1'b0;
    end else if (win_found) begin
      take_d = 1'b1;
      vec_d  = VEC_W'(PERIPH_VEC_BASE) + VEC_W'(win_idx);
      push   = 1'b1;
      ilm_d  = win_lvl;
      ssel_d = 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_ILM)) begin
        ilm_d = (wr_data < LVL_W'(LVL_FLOOR)) ? LVL_W'(LVL_FLOOR) : wr_data;
      end else if (wr_addr == ADDR_W'(ADDR_FLAGS)) begin
        ien_d  = wr_data[0];
        ssel_d = wr_data[1];
      end
    end
    if (push && stk_full) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ilm_q      <= LVL_W'(LVL_OFF);
      ien_q      <= 1'b0;
      ssel_q     <= 1'b1;
      undef_q    <= 1'b0;
      nmi_prev_q <= 1'b0;
      nmi_pend_q <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      ilm_q      <= ilm_d;
      ien_q      <= ien_d;
      ssel_q     <= ssel_d;
      undef_q    <= undef_d;
      nmi_prev_q <= nmi_in;
      nmi_pend_q <= nmi_pend_d;
      take_q     <= take_d;
      vec_q      <= vec_d;
      err_q      <= err_d;
    end
  end

  assign take_stb = take_q;
  assign take_vec = vec_q;
  assign ilm_o    = ilm_q;
  assign ien_o    = ien_q;
  assign ssel_o   = ssel_q;
  assign stk_err  = err_q;

  // R8: an undefined-opcode strobe is accepted next cycle with its vector, enable cleared
  assert_undef_take_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (undef_stb && !reti_stb) |=> (take_stb && take_vec == VEC_W'(UNDEF_VEC) && !ien_o));
  // R8: NMI is never accepted while the undefined-opcode handler runs
  assert_nmi_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    undef_q |=> !(take_stb && take_vec == VEC_W'(NMI_VEC)));
  // R7: NMI acceptance carries mask 15
  assert_nmi_level_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (take_stb && take_vec == VEC_W'(NMI_VEC)) |-> (ilm_o == LVL_W'(LVL_NMI)));
  // R9: every acceptance leaves the system stack selected
  assert_entry_sys_stack_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    take_stb |-> !ssel_o);
  // R6: the mask never falls below the NMI level
  assert_ilm_floor_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ilm_q >= LVL_W'(LVL_NMI));
  // R12: nothing is accepted in a return cycle
  assert_no_take_on_ret_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    reti_stb |=> !take_stb);
  // R11: the overflow flag is sticky
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    stk_err |=> stk_err);
endmodule

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;
  localparam int NS   = 8;
  localparam int BASE = 16;
  localparam int UV   = 14;
  localparam int NV   = 15;
  localparam int AW   = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_req, src_en;
  logic          nmi_in, undef_stb, wr_en, reti_stb;
  logic [AW-1:0] wr_addr;
  logic [4:0]    wr_data;
  logic          take_stb, ien_o, ssel_o, stk_err;
  logic [7:0]    take_vec;
  logic [4:0]    ilm_o;

  int n_chk = 0;
  int n_fail = 0;
  int lv [NS/2];
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .nmi_in(nmi_in), .undef_stb(undef_stb), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reti_stb(reti_stb), .take_stb(take_stb),
    .take_vec(take_vec), .ilm_o(ilm_o), .ien_o(ien_o), .ssel_o(ssel_o),
    .stk_err(stk_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = 5'(d);
    step;
    wr_en = 1'b0;
  endtask

  task automatic set_flags(input bit i, input bit s);
    wr(NS/2 + 1, {3'b000, s, i});
  endtask

  task automatic set_ilm(input int v);
    wr(NS/2, v);
  endtask

  task automatic do_reti;
    reti_stb = 1'b1;
    step;
    reti_stb = 1'b0;
  endtask

  task automatic pulse_undef;
    undef_stb = 1'b1;
    step;
    undef_stb = 1'b0;
  endtask

  task automatic lf_next;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  function automatic int model_win(input logic [NS-1:0] mask);
    int best = -1;
    int bl = 99;
    for (int i = 0; i < NS; i++) begin
      if (mask[i] && lv[i/2] != 31 && lv[i/2] < bl) begin
        best = i;
        bl = lv[i/2];
      end
    end
    return best;
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; src_en = '0; nmi_in = 1'b0; undef_stb = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; reti_stb = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    repeat (3) step;

    // R1 reset state
    chk(!take_stb, "R1 strobe", int'(take_stb), 0);
    chk(ilm_o == 31, "R1 mask", int'(ilm_o), 31);
    chk(!ien_o, "R1 enable", int'(ien_o), 0);
    chk(ssel_o, "R1 stack select", int'(ssel_o), 1);
    chk(!stk_err, "R1 error", int'(stk_err), 0);
    src_en = '1;
    set_flags(1, 1);
    set_ilm(31);
    src_req = '1;
    step;
    src_req = '0;
    chk(!take_stb, "R1 levels off after reset", int'(take_stb), 0);

    // R2 R4 R5 R9 R10 R12: each source alone, several levels
    for (int s = 0; s < NS; s++) begin
      for (int li = 0; li < 4; li++) begin
        int lvl;
        bit exp;
        lvl = (li == 0) ? 16 : (li == 1) ? 21 : (li == 2) ? 30 : 31;
        exp = (lvl != 31);
        wr(s/2, lvl);
        set_flags(1, 1);
        set_ilm(31);
        src_req[s] = 1'b1;
        step;
        src_req = '0;
        chk(take_stb == exp, "R2 shared level take", int'(take_stb), int'(exp));
        if (exp) begin
          chk(take_vec == 8'(BASE + s), "R4 vector", int'(take_vec), BASE + s);
          chk(ilm_o == 5'(lvl), "R5 mask from level", int'(ilm_o), lvl);
          chk(ien_o, "R5 enable kept", int'(ien_o), 1);
          chk(!ssel_o, "R9 stack select cleared", int'(ssel_o), 0);
        end
        step;
        chk(!take_stb, "R12 single-cycle strobe", int'(take_stb), 0);
        if (exp) begin
          do_reti;
          chk(ilm_o == 31, "R10 mask restored", int'(ilm_o), 31);
          chk(ien_o && ssel_o, "R10 flags restored", int'({ien_o, ssel_o}), 3);
        end
        wr(s/2, 31);
      end
    end

    // R3 qualification grid on source 2
    for (int li = 0; li < 3; li++) begin
      for (int mi = 0; mi < 4; mi++) begin
        for (int ii = 0; ii < 2; ii++) begin
          for (int ee = 0; ee < 2; ee++) begin
            int l;
            int m;
            bit exp;
            l = (li == 0) ? 16 : (li == 1) ? 23 : 30;
            m = (mi == 0) ? 16 : (mi == 1) ? 23 : (mi == 2) ? 30 : 31;
            exp = (ee == 1) && (ii == 1) && (l <= m);
            wr(1, l);
            set_ilm(m);
            set_flags(ii[0], 1);
            src_en = (ee == 1) ? 8'hFF : 8'hFB;
            src_req[2] = 1'b1;
            step;
            src_req = '0;
            chk(take_stb == exp, "R3 qualification", int'(take_stb), int'(exp));
            if (take_stb) do_reti;
          end
        end
      end
    end
    src_en = '1;
    wr(1, 31);

    // R4 priority over pseudo-random masks and levels
    for (int t = 0; t < 40; t++) begin
      logic [NS-1:0] mask;
      int w;
      for (int p = 0; p < NS/2; p++) begin
        lf_next;
        lv[p] = 16 + int'(lf[3:0]);
        wr(p, lv[p]);
      end
      lf_next;
      mask = lf[7:0];
      if (t == 0) begin
        for (int p = 0; p < NS/2; p++) begin lv[p] = 20; wr(p, 20); end
        mask = 8'b0011_0000;
      end
      w = model_win(mask);
      set_flags(1, 1);
      set_ilm(31);
      src_req = mask;
      step;
      src_req = '0;
      chk(take_stb == (w >= 0), "R4 any winner", int'(take_stb), int'(w >= 0));
      if (w >= 0) begin
        chk(take_vec == 8'(BASE + w), "R4 lowest level then lowest index",
            int'(take_vec), BASE + w);
        chk(ilm_o == 5'(lv[w/2]), "R5 mask from winner", int'(ilm_o), lv[w/2]);
      end
      if (take_stb) do_reti;
    end
    for (int p = 0; p < NS/2; p++) wr(p, 31);

    // R6 mask write clamp, all values
    for (int v = 0; v < 32; v++) begin
      set_ilm(v);
      chk(ilm_o == 5'((v < 16) ? 16 : v), "R6 mask clamp", int'(ilm_o), (v < 16) ? 16 : v);
    end
    // R2 level write clamp seen through acceptance
    wr(0, 5);
    set_ilm(16);
    set_flags(1, 1);
    src_req[0] = 1'b1;
    step;
    src_req = '0;
    chk(take_stb && ilm_o == 16, "R2 level clamp", int'(ilm_o), 16);
    if (take_stb) do_reti;
    wr(0, 31);

    // R7 NMI: unmaskable, edge taken, mask 15
    set_ilm(16);
    set_flags(0, 1);
    nmi_in = 1'b1;
    step;
    chk(take_stb && take_vec == 8'(NV), "R7 NMI taken with enable off", int'(take_vec), NV);
    chk(ilm_o == 15, "R7 mask 15", int'(ilm_o), 15);
    chk(!ssel_o, "R9 stack select on NMI", int'(ssel_o), 0);
    step;
    chk(!take_stb, "R7 held line not retaken", int'(take_stb), 0);
    nmi_in = 1'b0;
    set_flags(1, 0);
    wr(0, 16);
    src_req[0] = 1'b1;
    step;
    src_req = '0;
    chk(!take_stb, "R7 level 16 held off", int'(take_stb), 0);
    do_reti;
    chk(ilm_o == 16 && !ien_o && ssel_o, "R10 state after NMI return",
        int'({ilm_o, ien_o, ssel_o}), int'({5'd16, 1'b0, 1'b1}));
    wr(0, 31);

    // R8 undefined opcode: wins, clears enable, holds NMI pending
    set_flags(1, 1);
    set_ilm(31);
    wr(0, 16);
    undef_stb = 1'b1;
    nmi_in = 1'b1;
    src_req[0] = 1'b1;
    step;
    undef_stb = 1'b0;
    src_req = '0;
    chk(take_stb && take_vec == 8'(UV), "R8 undefined wins", int'(take_vec), UV);
    chk(!ien_o && !ssel_o && ilm_o == 31, "R8 entry state",
        int'({ilm_o, ien_o, ssel_o}), int'({5'd31, 1'b0, 1'b0}));
    for (int k = 0; k < 3; k++) begin
      step;
      chk(!take_stb, "R8 NMI held off in handler", int'(take_stb), 0);
    end
    reti_stb = 1'b1;
    step;
    reti_stb = 1'b0;
    chk(!take_stb, "R12 no take in return cycle", int'(take_stb), 0);
    chk(ien_o && ssel_o && ilm_o == 31, "R10 undefined return",
        int'({ilm_o, ien_o, ssel_o}), int'({5'd31, 1'b1, 1'b1}));
    step;
    chk(take_stb && take_vec == 8'(NV), "R8 pending NMI after return", int'(take_vec), NV);
    nmi_in = 1'b0;
    do_reti;
    chk(ilm_o == 31, "R10 mask after NMI", int'(ilm_o), 31);
    wr(0, 31);

    // R11 overflow
    set_flags(1, 1);
    set_ilm(31);
    for (int k = 0; k < 4; k++) pulse_undef;
    chk(!stk_err, "R11 four entries fit", int'(stk_err), 0);
    pulse_undef;
    chk(stk_err, "R11 fifth entry overflows", int'(stk_err), 1);
    for (int k = 0; k < 4; k++) do_reti;
    chk(ilm_o == 31 && ien_o && ssel_o, "R11 bottom entry intact",
        int'({ilm_o, ien_o, ssel_o}), int'({5'd31, 1'b1, 1'b1}));
    chk(stk_err, "R11 error sticky", int'(stk_err), 1);
    do_reti;
    chk(ilm_o == 31 && ien_o && ssel_o, "R10 empty return ignored",
        int'({ilm_o, ien_o, ssel_o}), int'({5'd31, 1'b1, 1'b1}));

    // R1 reset clears the error
    rst_n = 1'b0;
    step;
    rst_n = 1'b1;
    repeat (3) step;
    chk(!stk_err && ilm_o == 31 && !ien_o, "R1 state after second reset",
        int'(stk_err), 0);

    finish_run;
  end
endmodule